// File: doc/BRIEF.md
# Function Input Priority Multiplexer

This block carries pad input levels back to the input wires of peripheral functions. Each pin has a small select field. The same field already steers function outputs onto that pin, so one setting serves a bidirectional function in both directions. The block is organised per function. For each function input it works out which pins could feed it, finds those whose select field currently names it, and passes exactly one of their levels through.

Some function inputs can be fed from several pins. When two or more of those pins name the function at the same time, a fixed order grants the lowest-numbered pin. The other pins cannot disturb the result, so no contention arises. A function that only one pin can reach, such as a general-purpose input, needs no arbitration and is built as a single AND term. The block has no clock and no storage. Its outputs follow its inputs combinationally.

Default layout: 8 pins and a 2-bit select per pin. That gives 8 general-purpose inputs (functions 0..7) and 4 shared function inputs (functions 8..11).

Top module: `fn_input_router`

## Requirements
- R1: Function p (0 <= p < NUM_PINS) is a single-source general-purpose input: it equals pad_in[p] when pin p's select is 0, and is 0 otherwise.
- R2: Select value 1 or 2 on pin p connects pin p to shared function NUM_PINS + ((p + select) mod NUM_SHARED).
- R3: When several pins currently select the same shared function, only the lowest-indexed of them feeds it.
- R4: A function input that no pin currently selects reads 0, whatever the pad levels.
- R5: Select value 3 names an output-only function. A pin set to 3 drives no function input.
- R6: The level of a selecting pin that lost arbitration has no effect on the function input.
- R7: Outputs follow pad_in and pin_sel combinationally, with no clock and no added latency.
- R8: The pin chosen by R3 is decided by pin index alone and not by the select value through which each pin reaches the function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pad_in | input | NUM_PINS | Level received from each pad |
| pin_sel | input | NUM_PINS*SEL_W | Per-pin select fields; pin p occupies bits [p*SEL_W +: SEL_W] |
| fn_in | output | NUM_FUNCS | Input wire delivered to each function |

## Verification
The hardest case to reach is a contest in which the pins competing for one shared function reach it through different select values. This matters because it shows the grant depends on pin index and not on the encoding. To set it up, the bench makes pin 2 name function 8 through select 2 while pins 3 and 7 name it through select 1. It then drives opposite levels on winner and losers, and after that toggles only the losers. A running pseudo-random sweep, checked against a model written from the requirements, adds many further overlaps.

// File: rtl/fn_input_router_pkg.sv
// Package: compile-time routing map shared by the router modules.
// Assumes slot 0 = per-pin general-purpose input, slots 1..2 = shared
// functions, slot 3 = output-only (no input path).
package fn_input_router_pkg;

    localparam int SLOT_GPIO     = 0;
    localparam int SLOT_SHARED_A = 1;
    localparam int SLOT_SHARED_B = 2;

    // Returns the select value through which pin p reaches function f, or -1.
    function automatic int slot_of(input int f, input int p,
                                   input int num_pins, input int num_shared);
        if (f < num_pins) begin
            return (f == p) ? SLOT_GPIO : -1;
        end
        for (int k = SLOT_SHARED_A; k <= SLOT_SHARED_B; k++) begin
            if (((p + k) % num_shared) == (f - num_pins)) begin
                return k;
            end
        end
        return -1;
    endfunction

    // Number of pins that can ever feed function f.
    function automatic int source_count(input int f, input int num_pins,
                                        input int num_shared);
        int n;
        n = 0;
        for (int p = 0; p < num_pins; p++) begin
            if (slot_of(f, p, num_pins, num_shared) >= 0) begin
                n++;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fn_input_match.sv
// Module: fn_input_match
// Builds, for one function, the vector of pins whose select field currently
// names that function. Assumes the map in fn_input_router_pkg; pins that can
// never reach the function are tied to 0 at elaboration.
module fn_input_match
    import fn_input_router_pkg::*;
#(
    parameter int FUNC_IDX   = 0,
    parameter int NUM_PINS   = 8,
    parameter int NUM_SHARED = 4,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_PINS*SEL_W-1:0] pin_sel,
    output logic [NUM_PINS-1:0]       req
);

    localparam logic [SEL_W-1:0] OUT_ONLY_SEL = '1;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            localparam int SLOT = slot_of(FUNC_IDX, p, NUM_PINS, NUM_SHARED);
            if (SLOT >= 0) begin : g_reach
                // Pin p requests this function when its select names the slot.
                assign req[p] = (pin_sel[p*SEL_W +: SEL_W] == SEL_W'(SLOT));
            end else begin : g_unreach
                assign req[p] = 1'b0;
            end

            // Check that an output-only select never raises a request.
            always_comb begin
                if (pin_sel[p*SEL_W +: SEL_W] == OUT_ONLY_SEL) begin
                    p_out_only_silent_r5: assert (req[p] == 1'b0)
                        else $error("pin %0d requests function %0d on output-only select", p, FUNC_IDX);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fn_input_pick.sv
// Module: fn_input_pick
// Delivers one pad level to one function input. With several possible
// sources it grants the lowest-indexed requesting pin; with a single source
// it reduces to an AND gate. Assumes req has at most one bit set in the
// single-source variant (guaranteed by the routing map).
module fn_input_pick #(
    parameter int NUM_PINS = 8,
    parameter bit SINGLE   = 1'b0
) (
    input  logic [NUM_PINS-1:0] req,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic                fn_o
);

    generate
        if (SINGLE) begin : g_and
            // Single source: level gated by that pin's select match.
            assign fn_o = |(req & pad_in);
        end else begin : g_prio
            logic [NUM_PINS-1:0] grant;

            // Fixed priority: lowest requesting pin index wins.
            always_comb begin
                logic found;
                found = 1'b0;
                grant = '0;
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (req[i] && !found) begin
                        grant[i] = 1'b1;
                        found    = 1'b1;
                    end
                end
            end

            // Level of the granted pin only.
            assign fn_o = |(grant & pad_in);

            // Check grant is exclusive, requested, and lowest among requests.
            always_comb begin
                p_grant_onehot_r3: assert ($onehot0(grant))
                    else $error("multiple grants %b", grant);
                p_grant_requested_r3: assert ((grant & ~req) == '0)
                    else $error("grant %b outside req %b", grant, req);
                if (grant != '0) begin
                    p_lowest_wins_r8: assert (((grant - 1'b1) & req) == '0)
                        else $error("lower pin bypassed: req %b grant %b", req, grant);
                end
                if (req != '0) begin
                    p_someone_granted_r3: assert (grant != '0)
                        else $error("requests %b but no grant", req);
                end
            end
        end
    endgenerate

    // Check an unselected function reads 0.
    always_comb begin
        if (req == '0) begin
            p_idle_zero_r4: assert (fn_o == 1'b0)
                else $error("function driven with no request");
        end
    end

endmodule

// File: rtl/fn_input_router.sv
// Module: fn_input_router (top)
// Routes pad input levels to function inputs using the per-pin select
// fields shared with output routing. One match + pick pair per function;
// single-source functions become AND gates. Purely combinational.
// Assumes NUM_FUNCS = NUM_PINS + NUM_SHARED and SEL_W >= 2.
module fn_input_router
    import fn_input_router_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int NUM_SHARED = 4,
    parameter int SEL_W      = 2,
    parameter int NUM_FUNCS  = NUM_PINS + NUM_SHARED
) (
    input  logic [NUM_PINS-1:0]       pad_in,
    input  logic [NUM_PINS*SEL_W-1:0] pin_sel,
    output logic [NUM_FUNCS-1:0]      fn_in
);

    genvar f;
    generate
        for (f = 0; f < NUM_FUNCS; f++) begin : g_func
            localparam int NSRC = source_count(f, NUM_PINS, NUM_SHARED);
            if (NSRC == 0) begin : g_none
                assign fn_in[f] = 1'b0;
            end else begin : g_route
                logic [NUM_PINS-1:0] req;

                fn_input_match #(
                    .FUNC_IDX  (f),
                    .NUM_PINS  (NUM_PINS),
                    .NUM_SHARED(NUM_SHARED),
                    .SEL_W     (SEL_W)
                ) u_match (
                    .pin_sel(pin_sel),
                    .req    (req)
                );

                fn_input_pick #(
                    .NUM_PINS(NUM_PINS),
                    .SINGLE  (NSRC == 1)
                ) u_pick (
                    .req   (req),
                    .pad_in(pad_in),
                    .fn_o  (fn_in[f])
                );
            end
        end
    endgenerate

    // Check a general-purpose input is high only if its own pin selects slot 0 and is high.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            if (fn_in[p]) begin
                p_gpio_source_r1: assert (pad_in[p] && (pin_sel[p*SEL_W +: SEL_W] == '0))
                    else $error("gpio input %0d high without its pin", p);
            end
        end
    end

endmodule

// File: tb/fn_input_router_tb.sv
module fn_input_router_tb;

    localparam int NP = 8;
    localparam int NS = 4;
    localparam int SW = 2;
    localparam int NF = NP + NS;

    logic          clk = 1'b0;
    logic [NP-1:0] pad_in;
    logic [NP*SW-1:0] pin_sel;
    logic [NF-1:0] fn_in;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fn_input_router #(.NUM_PINS(NP), .NUM_SHARED(NS), .SEL_W(SW)) u_dut (
        .pad_in (pad_in),
        .pin_sel(pin_sel),
        .fn_in  (fn_in)
    );

    // Model from R1..R5: lowest pin whose select names f supplies its level.
    function automatic logic model(int f);
        for (int p = 0; p < NP; p++) begin
            int k;
            bit hit;
            k = int'(pin_sel[p*SW +: SW]);
            if (f < NP) hit = (p == f) && (k == 0);
            else        hit = (k == 1 || k == 2) && ((NP + ((p + k) % NS)) == f);
            if (hit) return pad_in[p];
        end
        return 1'b0;
    endfunction

    task automatic set_sel(int p, int v);
        pin_sel[p*SW +: SW] = SW'(v);
    endtask

    task automatic check_bit(string rq, int f, logic exp);
        checks++;
        if (fn_in[f] !== exp) begin
            failures++;
            $display("FAIL %s fn_in[%0d] actual=%b expected=%b", rq, f, fn_in[f], exp);
        end
    endtask

    task automatic check_all(string rq);
        for (int f = 0; f < NF; f++) check_bit(rq, f, model(f));
    endtask

    // Apply at the falling edge, sample mid low phase.
    task automatic settle();
        #5;
    endtask

    task automatic t_idle();
        @(negedge clk);
        pad_in = '1;
        pin_sel = '1;  // all output-only
        settle();
        for (int f = 0; f < NF; f++) check_bit("R5", f, 1'b0);
        pad_in = '0;
        pin_sel = '0;
        settle();
        for (int f = 0; f < NF; f++) check_bit("R4", f, 1'b0);
    endtask

    task automatic t_gpio();
        @(negedge clk);
        pin_sel = '0;
        pad_in = 8'b1010_0110;
        settle();
        for (int p = 0; p < NP; p++) check_bit("R1", p, pad_in[p]);
        for (int f = NP; f < NF; f++) check_bit("R4", f, 1'b0);
        pad_in = 8'b0101_1001;  // R7: same edge, new value
        settle();
        for (int p = 0; p < NP; p++) check_bit("R7", p, pad_in[p]);
    endtask

    task automatic t_shared_single();
        @(negedge clk);
        pin_sel = '1;
        pad_in = '1;
        set_sel(0, 1);  // -> function 9
        set_sel(5, 2);  // -> 8 + (7 mod 4) = 11
        settle();
        check_bit("R2", 9, 1'b1);
        check_bit("R2", 11, 1'b1);
        check_bit("R2", 8, 1'b0);
        check_bit("R2", 10, 1'b0);
        check_bit("R1", 0, 1'b0);  // pin 0 is not on slot 0
        pad_in[5] = 1'b0;
        settle();
        check_bit("R2", 11, 1'b0);
    endtask

    task automatic t_contention();
        @(negedge clk);
        pin_sel = '1;
        pad_in = '0;
        set_sel(2, 2);  // -> 8 via select 2
        set_sel(3, 1);  // -> 8 via select 1
        set_sel(7, 1);  // -> 8 via select 1
        pad_in[3] = 1'b1;
        pad_in[7] = 1'b1;
        settle();
        check_bit("R8", 8, 1'b0);  // pin 2 wins, low
        pad_in[2] = 1'b1;
        settle();
        check_bit("R3", 8, 1'b1);
        pad_in[3] = 1'b0;
        pad_in[7] = 1'b0;
        settle();
        check_bit("R6", 8, 1'b1);
        pad_in[2] = 1'b0;
        pad_in[3] = 1'b1;
        settle();
        check_bit("R6", 8, 1'b0);
        set_sel(2, 3);  // pin 2 withdraws; pin 3 wins
        settle();
        check_bit("R3", 8, 1'b1);
        set_sel(3, 0);  // pin 3 to gpio; pin 7 wins (low)
        settle();
        check_bit("R3", 8, 1'b0);
        check_bit("R1", 3, 1'b1);
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pin_sel = lfsr[NP*SW-1:0];
            pad_in = lfsr[31:24];
            settle();
            check_all("R3");
        end
    endtask

    initial begin
        pad_in = '0;
        pin_sel = '1;
        repeat (2) @(posedge clk);
        t_idle();
        t_gpio();
        t_shared_single();
        t_contention();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule